// File: doc/BRIEF.md
# Directional Rectangle Copy Engine

This block moves a rectangle of pixels from one region of a flat, byte-addressed frame memory to another. Software sets up the geometry on a bundle of configuration inputs: source and destination coordinates, rectangle size, row pitches, base offsets, two traversal-direction bits, a pixel format code and a mode bit. It then pulses `start`. The engine latches the whole bundle and checks it. It then walks the rectangle one pixel at a time over a single-port memory interface, reading each source pixel and writing it to the destination on the next cycle.

The direction bits say whether the given X and Y name the left or right edge and the top or bottom edge of the rectangle. They also set the order of the walk, so that a copy between overlapping regions gives the same result as a copy through a scratch buffer. A bad format, a zero pitch, an edge that is out of range, or a footprint that runs past the end of memory ends the operation before any memory cycle. When a copy succeeds, the engine returns the advanced destination position so that the next operation can continue from there.

Top module: `rect_copy_engine`

## Requirements
- R1: The low 4 bits of `cfg_fmt` set the pixel size: 2 gives 1 byte, 3 or 4 give 2 bytes, 5 gives 3 bytes and 6 gives 4 bytes. Writes enable the low byte lanes of `mem_be` to match (0001, 0011, 0111, 1111). Any other code ends the operation with `err_code`=1 and makes no memory access.
- R2: When `cfg_x_ltr`=0 the left edge is X+1-width, and when `cfg_y_ttb`=0 the top edge is Y+1-height, for source and destination alike. Arithmetic is modulo 2^16.
- R3: With `cfg_own_geom`=1 the separate source and destination pitches and offsets are used. With `cfg_own_geom`=0 the shared default pitch and offset serve both.
- R4: A zero destination pitch or a zero source pitch ends the operation with `err_code`=2 and makes no memory access.
- R5: If a left or top edge exceeds 0x3FFF, or if base >= memory size, or if base + left + (top + height) × pitch >= memory size, the operation ends with `err_code`=3 and makes no memory access. Errors are ranked as follows: format, destination pitch, destination range, source pitch, source range.
- R6: With `cfg_alt_dev`=1, bits [26:0] of `cfg_disp_base` are added to both bases, and each pitch is multiplied by the bits-per-pixel value (8, 16, 24 or 32).
- R7: The destination ends up exactly as if every source pixel had first been copied to a scratch buffer, including when the regions overlap. Pixels are walked in the order the direction bits give.
- R8: On success, `dst_x_next` becomes left+width when moving left to right and the left edge otherwise. `dst_y_next` becomes top+height when moving top to bottom and the top edge otherwise. Both are flagged by `wb_valid`. On an error, both keep their previous values.
- R9: `busy` is high from the cycle after an accepted `start` until `done` pulses for one cycle with `busy` low. A `start` while busy is ignored and the latched settings do not change.
- R10: Each pixel is read in one cycle and written in the next, with the data that was read. Reads and writes never share a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a copy using the current settings |
| cfg_src_x | input | CW | Source X (left or right edge) |
| cfg_src_y | input | CW | Source Y (top or bottom edge) |
| cfg_dst_x | input | CW | Destination X (left or right edge) |
| cfg_dst_y | input | CW | Destination Y (top or bottom edge) |
| cfg_width | input | CW | Rectangle width in pixels |
| cfg_height | input | CW | Rectangle height in rows |
| cfg_src_pitch | input | PW | Source row pitch (own mode) |
| cfg_dst_pitch | input | PW | Destination row pitch (own mode) |
| cfg_def_pitch | input | PW | Shared default pitch |
| cfg_src_off | input | OW | Source base offset (own mode) |
| cfg_dst_off | input | OW | Destination base offset (own mode) |
| cfg_def_off | input | OW | Shared default offset |
| cfg_x_ltr | input | 1 | 1 = left to right |
| cfg_y_ttb | input | 1 | 1 = top to bottom |
| cfg_fmt | input | 8 | Pixel format code (low 4 bits decoded) |
| cfg_own_geom | input | 1 | 1 = per-side pitch and offset |
| cfg_alt_dev | input | 1 | Alternate addressing mode |
| cfg_disp_base | input | 32 | Display base added in alternate mode |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err_code | output | 2 | 0 ok, 1 format, 2 zero pitch, 3 out of range |
| wb_valid | output | 1 | Pulses with `done` when new coordinates are valid |
| dst_x_next | output | CW | Advanced destination X |
| dst_y_next | output | CW | Advanced destination Y |
| mem_addr | output | AW | Byte address |
| mem_re | output | 1 | Read strobe (data one cycle later) |
| mem_we | output | 1 | Write strobe |
| mem_be | output | 4 | Byte-lane enables |
| mem_wdata | output | 32 | Write data, pixel in the low lanes |
| mem_rdata | input | 32 | Read data |

## Verification
Two of the block's functions can meet in the same cycle: the walk of an ongoing copy and the start-ignore logic. The bench provokes this by pulsing `start` a few cycles into a copy, with the destination X changed on the inputs. It judges the outcome by requiring exactly one `done`, a memory image equal to the first copy alone, and write-back coordinates from the first settings. A second meeting point is the read-then-write pairing under overlap. Right-to-left and bottom-to-top copies shift a region onto itself, and the bench compares every byte of memory with a scratch-buffer model.

// File: rtl/rect_copy_pkg.sv
package rect_copy_pkg;

  typedef enum logic [1:0] {
    ERR_NONE  = 2'd0,
    ERR_FMT   = 2'd1,
    ERR_PITCH = 2'd2,
    ERR_RANGE = 2'd3
  } copy_err_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_READ,
    ST_WRITE,
    ST_FIN
  } walk_st_e;

  localparam int DISP_MASK_W = 27;

  // bytes per pixel for a format code, 0 when the code is not supported
  function automatic logic [2:0] fmt_bytes(input logic [3:0] code);
    case (code)
      4'd2:       return 3'd1;
      4'd3, 4'd4: return 3'd2;
      4'd5:       return 3'd3;
      4'd6:       return 3'd4;
      default:    return 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/rect_copy_setup.sv
module rect_copy_setup
  import rect_copy_pkg::*;
#(
  parameter int CW        = 16,
  parameter int PW        = 16,
  parameter int OW        = 32,
  parameter int XW        = 48,
  parameter int MEM_BYTES = 4096,
  parameter int MAX_EDGE  = 16'h3FFF
) (
  input  logic [3:0]    fmt,
  input  logic          own_geom,
  input  logic          alt_dev,
  input  logic          x_ltr,
  input  logic          y_ttb,
  input  logic [CW-1:0] src_x,
  input  logic [CW-1:0] src_y,
  input  logic [CW-1:0] dst_x,
  input  logic [CW-1:0] dst_y,
  input  logic [CW-1:0] width,
  input  logic [CW-1:0] height,
  input  logic [PW-1:0] src_pitch,
  input  logic [PW-1:0] dst_pitch,
  input  logic [PW-1:0] def_pitch,
  input  logic [OW-1:0] src_off,
  input  logic [OW-1:0] dst_off,
  input  logic [OW-1:0] def_off,
  input  logic [31:0]   disp_base,
  output logic [2:0]    pix_bytes,
  output logic [XW-1:0] src_base,
  output logic [XW-1:0] dst_base,
  output logic [XW-1:0] src_pitch_e,
  output logic [XW-1:0] dst_pitch_e,
  output logic [CW-1:0] src_left,
  output logic [CW-1:0] src_top,
  output logic [CW-1:0] dst_left,
  output logic [CW-1:0] dst_top,
  output copy_err_e     err
);

  localparam logic [CW-1:0] EDGE_LIM = CW'(MAX_EDGE);
  localparam logic [XW-1:0] MEM_END  = XW'(MEM_BYTES);

  function automatic logic [CW-1:0] lead_edge(input logic [CW-1:0] pos,
                                              input logic [CW-1:0] len,
                                              input logic          fwd);
    return fwd ? pos : pos + CW'(1) - len;
  endfunction

  function automatic logic off_limits(input logic [XW-1:0] base,
                                      input logic [CW-1:0] left,
                                      input logic [CW-1:0] top,
                                      input logic [CW-1:0] rows,
                                      input logic [XW-1:0] pitch);
    logic [XW-1:0] reach;
    reach = base + XW'(left) + (XW'(top) + XW'(rows)) * pitch;
    return (left > EDGE_LIM) || (top > EDGE_LIM) ||
           (base >= MEM_END) || (reach >= MEM_END);
  endfunction

  logic [PW-1:0] sp_raw, dp_raw;
  logic [OW-1:0] so_raw, do_raw;
  logic [XW-1:0] disp_add, bits_x;

  assign sp_raw   = own_geom ? src_pitch : def_pitch;
  assign dp_raw   = own_geom ? dst_pitch : def_pitch;
  assign so_raw   = own_geom ? src_off   : def_off;
  assign do_raw   = own_geom ? dst_off   : def_off;
  assign disp_add = alt_dev ? XW'(disp_base[DISP_MASK_W-1:0]) : '0;

  assign pix_bytes = fmt_bytes(fmt);
  assign bits_x    = XW'({pix_bytes, 3'b000});

  assign src_base    = XW'(so_raw) + disp_add;
  assign dst_base    = XW'(do_raw) + disp_add;
  assign src_pitch_e = alt_dev ? XW'(sp_raw) * bits_x : XW'(sp_raw);
  assign dst_pitch_e = alt_dev ? XW'(dp_raw) * bits_x : XW'(dp_raw);

  assign src_left = lead_edge(src_x, width,  x_ltr);
  assign dst_left = lead_edge(dst_x, width,  x_ltr);
  assign src_top  = lead_edge(src_y, height, y_ttb);
  assign dst_top  = lead_edge(dst_y, height, y_ttb);

  always_comb begin
    if (pix_bytes == 3'd0)
      err = ERR_FMT;
    else if (dp_raw == '0)
      err = ERR_PITCH;
    else if (off_limits(dst_base, dst_left, dst_top, height, dst_pitch_e))
      err = ERR_RANGE;
    else if (sp_raw == '0)
      err = ERR_PITCH;
    else if (off_limits(src_base, src_left, src_top, height, src_pitch_e))
      err = ERR_RANGE;
    else
      err = ERR_NONE;
  end

endmodule

// File: rtl/rect_copy_walker.sv
module rect_copy_walker
  import rect_copy_pkg::*;
#(
  parameter int CW = 16,
  parameter int AW = 12,
  parameter int XW = 48
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  copy_err_e     chk_err,
  input  logic [2:0]    pix_bytes,
  input  logic [XW-1:0] src_base,
  input  logic [XW-1:0] dst_base,
  input  logic [XW-1:0] src_pitch,
  input  logic [XW-1:0] dst_pitch,
  input  logic [CW-1:0] src_left,
  input  logic [CW-1:0] src_top,
  input  logic [CW-1:0] dst_left,
  input  logic [CW-1:0] dst_top,
  input  logic [CW-1:0] width,
  input  logic [CW-1:0] height,
  input  logic          x_ltr,
  input  logic          y_ttb,
  output logic          busy,
  output logic          done,
  output logic [1:0]    err_code,
  output logic          wb_valid,
  output logic [CW-1:0] dst_x_next,
  output logic [CW-1:0] dst_y_next,
  output logic [AW-1:0] mem_addr,
  output logic          mem_re,
  output logic          mem_we,
  output logic [3:0]    mem_be,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata
);

  walk_st_e      st;
  copy_err_e     err_q;
  logic [CW-1:0] xi, yi;
  logic [CW-1:0] x_first, y_first, x_final, y_final;
  logic          last_x, last_y;
  logic [XW-1:0] src_byte, dst_byte;

  assign x_first = x_ltr ? '0 : width - CW'(1);
  assign y_first = y_ttb ? '0 : height - CW'(1);
  assign x_final = x_ltr ? width - CW'(1) : '0;
  assign y_final = y_ttb ? height - CW'(1) : '0;
  assign last_x  = (xi == x_final);
  assign last_y  = (yi == y_final);

  assign src_byte = src_base + (XW'(src_top) + XW'(yi)) * src_pitch
                  + (XW'(src_left) + XW'(xi)) * XW'(pix_bytes);
  assign dst_byte = dst_base + (XW'(dst_top) + XW'(yi)) * dst_pitch
                  + (XW'(dst_left) + XW'(xi)) * XW'(pix_bytes);

  assign busy      = (st != ST_IDLE);
  assign mem_re    = (st == ST_READ);
  assign mem_we    = (st == ST_WRITE);
  assign mem_addr  = (st == ST_READ) ? AW'(src_byte) : AW'(dst_byte);
  assign mem_wdata = mem_rdata;

  always_comb begin
    case (pix_bytes)
      3'd1:    mem_be = 4'b0001;
      3'd2:    mem_be = 4'b0011;
      3'd3:    mem_be = 4'b0111;
      default: mem_be = 4'b1111;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      err_q      <= ERR_NONE;
      xi         <= '0;
      yi         <= '0;
      done       <= 1'b0;
      wb_valid   <= 1'b0;
      err_code   <= 2'd0;
      dst_x_next <= '0;
      dst_y_next <= '0;
    end else begin
      done     <= 1'b0;
      wb_valid <= 1'b0;
      case (st)
        ST_IDLE: if (go) st <= ST_CHECK;
        ST_CHECK: begin
          if (chk_err != ERR_NONE) begin
            err_q <= chk_err;
            st    <= ST_FIN;
          end else begin
            err_q <= ERR_NONE;
            xi    <= x_first;
            yi    <= y_first;
            st    <= (width == '0 || height == '0) ? ST_FIN : ST_READ;
          end
        end
        ST_READ: st <= ST_WRITE;
        ST_WRITE: begin
          if (last_x) begin
            xi <= x_first;
            if (last_y) begin
              st <= ST_FIN;
            end else begin
              yi <= y_ttb ? yi + CW'(1) : yi - CW'(1);
              st <= ST_READ;
            end
          end else begin
            xi <= x_ltr ? xi + CW'(1) : xi - CW'(1);
            st <= ST_READ;
          end
        end
        ST_FIN: begin
          done     <= 1'b1;
          err_code <= err_q;
          if (err_q == ERR_NONE) begin
            wb_valid   <= 1'b1;
            dst_x_next <= x_ltr ? dst_left + width  : dst_left;
            dst_y_next <= y_ttb ? dst_top  + height : dst_top;
          end
          st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R10
  wr_after_rd_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> $past(mem_re));

  // R1 R4 R5
  err_no_access_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_re || mem_we) |-> (chk_err == ERR_NONE));

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

endmodule

// File: rtl/rect_copy_engine.sv
module rect_copy_engine
  import rect_copy_pkg::*;
#(
  parameter int CW        = 16,
  parameter int PW        = 16,
  parameter int OW        = 32,
  parameter int AW        = 12,
  parameter int MEM_BYTES = 4096,
  parameter int MAX_EDGE  = 16'h3FFF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [CW-1:0] cfg_src_x,
  input  logic [CW-1:0] cfg_src_y,
  input  logic [CW-1:0] cfg_dst_x,
  input  logic [CW-1:0] cfg_dst_y,
  input  logic [CW-1:0] cfg_width,
  input  logic [CW-1:0] cfg_height,
  input  logic [PW-1:0] cfg_src_pitch,
  input  logic [PW-1:0] cfg_dst_pitch,
  input  logic [PW-1:0] cfg_def_pitch,
  input  logic [OW-1:0] cfg_src_off,
  input  logic [OW-1:0] cfg_dst_off,
  input  logic [OW-1:0] cfg_def_off,
  input  logic          cfg_x_ltr,
  input  logic          cfg_y_ttb,
  input  logic [7:0]    cfg_fmt,
  input  logic          cfg_own_geom,
  input  logic          cfg_alt_dev,
  input  logic [31:0]   cfg_disp_base,
  output logic          busy,
  output logic          done,
  output logic [1:0]    err_code,
  output logic          wb_valid,
  output logic [CW-1:0] dst_x_next,
  output logic [CW-1:0] dst_y_next,
  output logic [AW-1:0] mem_addr,
  output logic          mem_re,
  output logic          mem_we,
  output logic [3:0]    mem_be,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata
);

  localparam int XW = CW + PW + 16;

  logic          load;
  logic [CW-1:0] sx_q, sy_q, dx_q, dy_q, w_q, h_q;
  logic [PW-1:0] sp_q, dp_q, defp_q;
  logic [OW-1:0] so_q, do_q, defo_q;
  logic          ltr_q, ttb_q, own_q, alt_q;
  logic [3:0]    fmt_q;
  logic [31:0]   disp_q;

  assign load = start && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      {sx_q, sy_q, dx_q, dy_q, w_q, h_q} <= '0;
      {sp_q, dp_q, defp_q}               <= '0;
      {so_q, do_q, defo_q}               <= '0;
      {ltr_q, ttb_q, own_q, alt_q}       <= '0;
      fmt_q                              <= '0;
      disp_q                             <= '0;
    end else if (load) begin
      sx_q   <= cfg_src_x;     sy_q   <= cfg_src_y;
      dx_q   <= cfg_dst_x;     dy_q   <= cfg_dst_y;
      w_q    <= cfg_width;     h_q    <= cfg_height;
      sp_q   <= cfg_src_pitch; dp_q   <= cfg_dst_pitch;
      defp_q <= cfg_def_pitch;
      so_q   <= cfg_src_off;   do_q   <= cfg_dst_off;
      defo_q <= cfg_def_off;
      ltr_q  <= cfg_x_ltr;     ttb_q  <= cfg_y_ttb;
      own_q  <= cfg_own_geom;  alt_q  <= cfg_alt_dev;
      fmt_q  <= cfg_fmt[3:0];
      disp_q <= cfg_disp_base;
    end
  end

  copy_err_e     chk_err;
  logic [2:0]    pix_bytes;
  logic [XW-1:0] src_base, dst_base, src_pitch_e, dst_pitch_e;
  logic [CW-1:0] src_left, src_top, dst_left, dst_top;

  rect_copy_setup #(
    .CW(CW), .PW(PW), .OW(OW), .XW(XW),
    .MEM_BYTES(MEM_BYTES), .MAX_EDGE(MAX_EDGE)
  ) u_setup (
    .fmt(fmt_q), .own_geom(own_q), .alt_dev(alt_q),
    .x_ltr(ltr_q), .y_ttb(ttb_q),
    .src_x(sx_q), .src_y(sy_q), .dst_x(dx_q), .dst_y(dy_q),
    .width(w_q), .height(h_q),
    .src_pitch(sp_q), .dst_pitch(dp_q), .def_pitch(defp_q),
    .src_off(so_q), .dst_off(do_q), .def_off(defo_q),
    .disp_base(disp_q),
    .pix_bytes(pix_bytes),
    .src_base(src_base), .dst_base(dst_base),
    .src_pitch_e(src_pitch_e), .dst_pitch_e(dst_pitch_e),
    .src_left(src_left), .src_top(src_top),
    .dst_left(dst_left), .dst_top(dst_top),
    .err(chk_err)
  );

  rect_copy_walker #(.CW(CW), .AW(AW), .XW(XW)) u_walk (
    .clk(clk), .rst(rst), .go(load),
    .chk_err(chk_err), .pix_bytes(pix_bytes),
    .src_base(src_base), .dst_base(dst_base),
    .src_pitch(src_pitch_e), .dst_pitch(dst_pitch_e),
    .src_left(src_left), .src_top(src_top),
    .dst_left(dst_left), .dst_top(dst_top),
    .width(w_q), .height(h_q), .x_ltr(ltr_q), .y_ttb(ttb_q),
    .busy(busy), .done(done), .err_code(err_code), .wb_valid(wb_valid),
    .dst_x_next(dst_x_next), .dst_y_next(dst_y_next),
    .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we),
    .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(w_q) && $stable(h_q) && $stable(dx_q) && $stable(so_q)));

endmodule

// File: tb/rect_copy_engine_tb.sv
module rect_copy_engine_tb;

  localparam int CLK_PERIOD = 10;
  localparam int MEM = 4096;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        start = 1'b0;
  logic [15:0] sx, sy, dx, dy, w, h;
  logic [15:0] sp, dp, defp;
  logic [31:0] so, doff, defo, disp;
  logic        ltr, ttb, own, alt;
  logic [7:0]  fmt;

  logic        busy, done, wb_valid, mem_re, mem_we;
  logic [1:0]  err_code;
  logic [15:0] nx, ny;
  logic [11:0] mem_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata, mem_rdata;

  rect_copy_engine u_dut (
    .clk(clk), .rst(rst), .start(start),
    .cfg_src_x(sx), .cfg_src_y(sy), .cfg_dst_x(dx), .cfg_dst_y(dy),
    .cfg_width(w), .cfg_height(h),
    .cfg_src_pitch(sp), .cfg_dst_pitch(dp), .cfg_def_pitch(defp),
    .cfg_src_off(so), .cfg_dst_off(doff), .cfg_def_off(defo),
    .cfg_x_ltr(ltr), .cfg_y_ttb(ttb), .cfg_fmt(fmt),
    .cfg_own_geom(own), .cfg_alt_dev(alt), .cfg_disp_base(disp),
    .busy(busy), .done(done), .err_code(err_code), .wb_valid(wb_valid),
    .dst_x_next(nx), .dst_y_next(ny),
    .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we),
    .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // byte memory with one-cycle read latency
  logic [7:0] ram [MEM];
  logic [7:0] expm [MEM];
  logic [7:0] tmp [MEM];
  logic       fill_req = 1'b0;
  logic [7:0] seed = 8'd0;

  always @(posedge clk) begin
    if (fill_req) begin
      for (int i = 0; i < MEM; i++) ram[i] <= 8'(i * 13) + seed;
    end else begin
      if (mem_re)
        mem_rdata <= {ram[(int'(mem_addr) + 3) % MEM], ram[(int'(mem_addr) + 2) % MEM],
                      ram[(int'(mem_addr) + 1) % MEM], ram[int'(mem_addr)]};
      if (mem_we)
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) ram[(int'(mem_addr) + b) % MEM] <= mem_wdata[b*8 +: 8];
    end
  end

  // port monitor
  int         acc_cnt = 0, done_cnt = 0, order_bad = 0, data_bad = 0;
  logic       prev_re = 1'b0;
  logic [3:0] last_be = 4'd0;
  always @(posedge clk) begin
    if (mem_re || mem_we) acc_cnt <= acc_cnt + 1;
    if (done) done_cnt <= done_cnt + 1;
    if (mem_we) begin
      last_be <= mem_be;
      if (!prev_re) order_bad <= order_bad + 1;
      if (mem_wdata != mem_rdata) data_bad <= data_bad + 1;
    end
    prev_re <= mem_re;
  end

  int errs = 0, checks = 0;

  task automatic check(input logic ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic set_defaults();
    sx = 1; sy = 1; dx = 3; dy = 2; w = 5; h = 4;
    sp = 64; dp = 64; defp = 64;
    so = 0; doff = 2048; defo = 0; disp = 0;
    ltr = 1; ttb = 1; own = 1; alt = 0; fmt = 8'h02;
  endtask

  function automatic int bytes_for(input logic [3:0] c);
    if (c == 2) return 1;
    if (c == 3 || c == 4) return 2;
    if (c == 5) return 3;
    if (c == 6) return 4;
    return 0;
  endfunction

  function automatic bit beyond(input longint base, input longint l, input longint t,
                                input longint p);
    return l > 16383 || t > 16383 || base >= MEM || base + l + (t + longint'(h)) * p >= MEM;
  endfunction

  // scratch-buffer model of the copy on expm
  task automatic model(output int merr, output logic [15:0] mx, output logic [15:0] my);
    int B;
    longint spe, dpe, sb, db, dadd;
    logic [15:0] sl, st, dl, dt;
    B    = bytes_for(fmt[3:0]);
    spe  = own ? sp : defp;
    dpe  = own ? dp : defp;
    dadd = alt ? longint'(disp[26:0]) : 0;
    sb   = (own ? longint'(so) : longint'(defo)) + dadd;
    db   = (own ? longint'(doff) : longint'(defo)) + dadd;
    sl = ltr ? sx : 16'(sx + 1 - w);
    dl = ltr ? dx : 16'(dx + 1 - w);
    st = ttb ? sy : 16'(sy + 1 - h);
    dt = ttb ? dy : 16'(dy + 1 - h);
    mx = ltr ? 16'(dl + w) : dl;
    my = ttb ? 16'(dt + h) : dt;
    merr = 0;
    if (B == 0) merr = 1;
    else if (dpe == 0) merr = 2;
    else begin
      if (alt) begin spe = spe * B * 8; dpe = dpe * B * 8; end
      if (beyond(db, dl, dt, dpe)) merr = 3;
      else if (spe == 0) merr = 2;
      else if (beyond(sb, sl, st, spe)) merr = 3;
    end
    if (merr != 0) return;
    for (int j = 0; j < int'(h); j++)
      for (int i = 0; i < int'(w); i++)
        for (int k = 0; k < B; k++)
          tmp[((j * int'(w) + i) * B + k) % MEM] =
            expm[(sb + (st + j) * spe + (sl + i) * B + k) % MEM];
    for (int j = 0; j < int'(h); j++)
      for (int i = 0; i < int'(w); i++)
        for (int k = 0; k < B; k++)
          expm[(db + (dt + j) * dpe + (dl + i) * B + k) % MEM] =
            tmp[((j * int'(w) + i) * B + k) % MEM];
  endtask

  // one operation: fill, model, run, compare
  task automatic run_copy(input string req, input bit intrude);
    int merr, a0, d0, bad, first;
    logic [15:0] mx, my, px, py, gx, gy;
    logic [1:0] gerr;
    logic gwb, got;
    seed = seed + 8'd37;
    @(negedge clk) fill_req = 1'b1;
    @(negedge clk) fill_req = 1'b0;
    for (int i = 0; i < MEM; i++) expm[i] = 8'(i * 13) + seed;
    px = nx; py = ny;
    model(merr, mx, my);
    a0 = acc_cnt; d0 = done_cnt;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    got = 1'b0; gerr = 0; gwb = 0; gx = 0; gy = 0;
    for (int c = 0; c < 20000 && !got; c++) begin
      if (intrude && c == 3) begin
        dx = dx + 16'd5;
        start = 1'b1;
      end else start = 1'b0;
      @(negedge clk);
      if (done) begin got = 1'b1; gerr = err_code; gwb = wb_valid; gx = nx; gy = ny; end
    end
    start = 1'b0;
    check(got, req, "done seen", got, 1);
    check(gerr == 2'(merr), req, "err_code", gerr, merr);
    bad = 0; first = -1;
    for (int i = 0; i < MEM; i++)
      if (ram[i] !== expm[i]) begin bad++; if (first < 0) first = i; end
    check(bad == 0, req, "memory mismatches (first idx in actual)", first, -1);
    if (merr == 0) begin
      check(gwb == 1'b1, req, "wb_valid", gwb, 1);
      check(gx == mx, req, "dst_x_next", gx, mx);
      check(gy == my, req, "dst_y_next", gy, my);
      check(last_be == 4'((1 << bytes_for(fmt[3:0])) - 1), req, "mem_be", last_be,
            (1 << bytes_for(fmt[3:0])) - 1);
    end else begin
      check(acc_cnt == a0, req, "memory accesses on error", acc_cnt - a0, 0);
      check(gwb == 1'b0 && gx == px && gy == py, req, "coords held on error", gx, px);
    end
    repeat (12) @(negedge clk);
    check(done_cnt == d0 + 1 && !busy, req, "single done then idle", done_cnt - d0, 1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(!busy && !done && !mem_re && !mem_we, "R9", "idle after reset", busy, 0);
    check(nx == 0 && ny == 0, "R8", "coords reset", nx, 0);
  endtask

  task automatic t_formats();
    set_defaults(); run_copy("R1_R7_8bpp", 0);
    set_defaults(); fmt = 8'h33; w = 4; h = 3; run_copy("R1_16bpp_c3", 0);
    set_defaults(); fmt = 8'h04; w = 4; h = 3; run_copy("R1_16bpp_c4", 0);
    set_defaults(); fmt = 8'h05; w = 4; h = 3; run_copy("R1_24bpp", 0);
    set_defaults(); fmt = 8'h06; w = 3; h = 3; run_copy("R1_32bpp", 0);
    set_defaults(); fmt = 8'h07; run_copy("R1_badfmt", 0);
  endtask

  task automatic t_overlap();
    set_defaults(); so = 0; doff = 0; ltr = 0; sx = 10; dx = 12; sy = 2; dy = 2;
    w = 8; h = 3; run_copy("R2_R7_rtl_overlap", 0);
    set_defaults(); so = 0; doff = 0; ttb = 0; sx = 1; dx = 1; sy = 6; dy = 8;
    w = 6; h = 5; run_copy("R2_R7_btt_overlap", 0);
    set_defaults(); so = 0; doff = 0; ltr = 0; ttb = 0; fmt = 8'h03; sx = 9; dx = 8;
    sy = 9; dy = 10; w = 5; h = 4; run_copy("R2_R7_both_rev", 0);
  endtask

  task automatic t_modes();
    set_defaults(); own = 0; sp = 0; dp = 0; defp = 32; defo = 1024;
    sx = 0; sy = 0; dx = 8; dy = 6; run_copy("R3_default_geom", 0);
    set_defaults(); alt = 1; sp = 4; dp = 4; doff = 32'h400; disp = 32'hF800_0200;
    w = 3; h = 2; run_copy("R6_alt_dev", 0);
  endtask

  task automatic t_errors();
    set_defaults(); dp = 0; run_copy("R4_zero_dst_pitch", 0);
    set_defaults(); sp = 0; run_copy("R4_zero_src_pitch", 0);
    set_defaults(); ltr = 0; dx = 2; w = 5; run_copy("R5_edge_limit", 0);
    set_defaults(); doff = 4000; dy = 10; run_copy("R5_past_end", 0);
    set_defaults(); fmt = 8'h02; dp = 0; so = 9000; run_copy("R5_rank_pitch", 0);
  endtask

  task automatic t_busy_start();
    set_defaults(); w = 6; h = 4; run_copy("R9_start_while_busy", 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    set_defaults();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_formats();
    t_overlap();
    t_modes();
    t_errors();
    t_busy_start();
    check(order_bad == 0, "R10", "writes without preceding read", order_bad, 0);
    check(data_bad == 0, "R10", "write data differs from read", data_bad, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule